// File: doc/BRIEF.md
# ADC Mode Controller

This block sequences the operating modes of a sampling converter's digital core. It moves among four visible modes: held in reset, recovering from reset, acquiring the input, and converting. An external active-low reset pin, a conversion-start input and the serial clock are sampled through synchronizers. A configuration bit selects the reset flavour. The block drives a ready line, an output-enable for the serial data pins, and two single-cycle pulses. One pulse clears the configuration registers. The other resets the analog section.

A low pulse on the reset pin counts only once it has lasted a minimum number of cycles. While the pulse is still too short to count, the controller freezes in place, and if the pin rises in time it carries on as before. Leaving reset needs the start and clock inputs both low. A recovery delay follows, and its length depends on the flavour. After that the ready line rises and acquisition begins. A rising start edge in acquire mode runs a conversion of fixed length, and start activity during the conversion has no effect.

Top module: `cvt_mode_ctrl`

## Requirements
- R1: After the system reset `rst_n` is released, `mode_o` reads 2'b10 (acquire), `rdy_o` and `sdo_oe_o` are 1, and no pulse is issued.
- R2: When the synchronized reset pin has been low for MIN_RST_CYC consecutive clocks, the block enters reset (`mode_o` = 2'b00) from any mode. `rdy_o` and `sdo_oe_o` go to 0 and `cfg_clr_o` pulses for exactly one clock.
- R3: If `app_rst_sel_i` is 0 when a reset is accepted, `ana_rst_o` pulses in the same clock as `cfg_clr_o` and the long delay POR_DLY_CYC is used. If it is 1, `ana_rst_o` stays low and the short delay APP_DLY_CYC is used.
- R4: A low pulse shorter than MIN_RST_CYC clocks issues no pulse and leaves the mode unchanged. While the pin is low, the mode, the timers and start detection are frozen, so a conversion in progress is lengthened by exactly the pulse width.
- R5: Reset is left only in a clock where the synchronized pin is high and both synchronized `start_i` and `sclk_i` are low. Otherwise the block stays in reset.
- R6: Leaving reset enters recovery (`mode_o` = 2'b01). `rdy_o` rises, with the mode becoming acquire, exactly D+SYNC_STAGES+1 clocks after the last of pin-high, start-low and clock-low is applied, where D is the flavour's delay.
- R7: A rising edge of `start_i` in acquire mode enters conversion (`mode_o` = 2'b11). `rdy_o` falls SYNC_STAGES+1 clocks after the edge is applied.
- R8: A conversion keeps `rdy_o` low for exactly CONV_CYC clocks and then returns to acquire. Start toggling during the conversion has no effect, and a start held high afterwards does not begin another conversion.
- R9: Start edges seen in reset or recovery are ignored, so no conversion follows recovery.
- R10: A start rising edge that reaches the controller in the same clock as a falling reset pin is discarded, even when the reset pulse turns out too short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous to clk |
| start_i | input | 1 | Conversion start / select input |
| sclk_i | input | 1 | Serial clock input level |
| app_rst_sel_i | input | 1 | Reset flavour: 1 application, 0 power-on |
| rdy_o | output | 1 | Ready: high only in acquire mode |
| sdo_oe_o | output | 1 | Serial data output enable, low in reset and recovery |
| cfg_clr_o | output | 1 | One-clock configuration clear pulse |
| ana_rst_o | output | 1 | One-clock analog reset pulse (power-on flavour only) |
| mode_o | output | 2 | Current mode: 00 reset, 01 recovery, 10 acquire, 11 convert |

## Verification
Two functions can meet in one clock. A start rising edge can reach the controller together with the first low sample of the reset pin. The same low pin can also freeze a conversion that is already running. The bench provokes the first case by driving start high and the pin low at the same instant, for a pulse shorter than the minimum. It then requires that the ready line never drops and that no clear pulse appears. The second case is judged by counting the ready-low clocks of a conversion cut by a short pulse: the count must equal the conversion length plus the pulse width.

// File: rtl/cvt_mode_pkg.sv
package cvt_mode_pkg;

   typedef enum logic [1:0] {
      MD_RESET   = 2'b00,
      MD_RECOVER = 2'b01,
      MD_ACQ     = 2'b10,
      MD_CONV    = 2'b11
   } cvt_mode_e;

   localparam int SYNC_MIN_STAGES = 2;

endpackage

// File: rtl/cvt_sync.sv
module cvt_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < cvt_mode_pkg::SYNC_MIN_STAGES) begin : g_bad_stages
         $error("cvt_sync: STAGES below minimum");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("cvt_sync: WIDTH must be positive");
      end

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         logic [WIDTH-1:0] q;
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= RST_VAL;
               else        q <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= RST_VAL;
               else        q <= g_stage[s-1].q;
            end
         end
      end
   endgenerate

   assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/cvt_rst_qual.sv
module cvt_rst_qual #(
   parameter int MIN_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   output logic accept_o
);

   localparam int CW = $clog2(MIN_CYC + 1);

   generate
      if (MIN_CYC < 1) begin : g_bad_min
         $error("cvt_rst_qual: MIN_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] lo_cnt;

   assign accept_o = !pin_s && (lo_cnt == CW'(MIN_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
      end else if (pin_s) begin
         lo_cnt <= '0;
      end else if (lo_cnt != CW'(MIN_CYC)) begin
         lo_cnt <= lo_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/cvt_tmr.sv
module cvt_tmr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   input  logic         tick_i,
   output logic         zero_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("cvt_tmr: W must be positive");
      end
   endgenerate

   logic [W-1:0] cnt;

   assign zero_o = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load_i) begin
         cnt <= val_i;
      end else if (tick_i && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/cvt_mode_ctrl.sv
module cvt_mode_ctrl
   import cvt_mode_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_RST_CYC = 16,
   parameter int POR_DLY_CYC = 4000,
   parameter int APP_DLY_CYC = 200,
   parameter int CONV_CYC    = 60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rst_pin_n,
   input  logic       start_i,
   input  logic       sclk_i,
   input  logic       app_rst_sel_i,
   output logic       rdy_o,
   output logic       sdo_oe_o,
   output logic       cfg_clr_o,
   output logic       ana_rst_o,
   output logic [1:0] mode_o
);

   localparam int DLY_MAX = (POR_DLY_CYC > APP_DLY_CYC) ? POR_DLY_CYC : APP_DLY_CYC;
   localparam int CNT_MAX = (DLY_MAX > CONV_CYC) ? DLY_MAX : CONV_CYC;
   localparam int TW      = $clog2(CNT_MAX + 1);

   generate
      if (POR_DLY_CYC < 1 || APP_DLY_CYC < 1) begin : g_bad_dly
         $error("cvt_mode_ctrl: recovery delays must be at least 1");
      end
      if (CONV_CYC < 1) begin : g_bad_conv
         $error("cvt_mode_ctrl: CONV_CYC must be at least 1");
      end
   endgenerate

   // synchronized inputs: bit0 reset pin, bit1 start, bit2 serial clock
   logic [2:0] sync_in;
   logic [2:0] sync_out;
   logic       rst_pin_s;
   logic       start_s;
   logic       sclk_s;

   assign sync_in = {sclk_i, start_i, rst_pin_n};

   cvt_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b001)
   ) u_sync (
      .clk (clk),
      .rst_n(rst_n),
      .din (sync_in),
      .dout(sync_out)
   );

   assign rst_pin_s = sync_out[0];
   assign start_s   = sync_out[1];
   assign sclk_s    = sync_out[2];

   // start edge detector; runs even while frozen, so a masked edge is lost
   logic start_d;
   logic start_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_d <= 1'b0;
      else        start_d <= start_s;
   end

   assign start_rise = start_s & ~start_d;

   // reset pulse width qualification
   logic rst_acc;

   cvt_rst_qual #(
      .MIN_CYC(MIN_RST_CYC)
   ) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (rst_pin_s),
      .accept_o(rst_acc)
   );

   // shared mode timer for recovery and conversion
   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_tick;
   logic          tmr_zero;

   cvt_tmr #(
      .W(TW)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(tmr_load),
      .val_i (tmr_val),
      .tick_i(tmr_tick),
      .zero_o(tmr_zero)
   );

   cvt_mode_e state, state_n;
   logic      por_q;
   logic      pend;

   assign pend = ~rst_pin_s;

   always_comb begin
      state_n  = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      tmr_tick = 1'b0;
      if (rst_acc) begin
         state_n = MD_RESET;
      end else if (!pend) begin
         case (state)
            MD_RESET: begin
               if (!start_s && !sclk_s) begin
                  state_n  = MD_RECOVER;
                  tmr_load = 1'b1;
                  tmr_val  = por_q ? TW'(POR_DLY_CYC - 1) : TW'(APP_DLY_CYC - 1);
               end
            end
            MD_RECOVER: begin
               if (tmr_zero) state_n = MD_ACQ;
               else          tmr_tick = 1'b1;
            end
            MD_ACQ: begin
               if (start_rise) begin
                  state_n  = MD_CONV;
                  tmr_load = 1'b1;
                  tmr_val  = TW'(CONV_CYC - 1);
               end
            end
            MD_CONV: begin
               if (tmr_zero) state_n = MD_ACQ;
               else          tmr_tick = 1'b1;
            end
            default: state_n = MD_ACQ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= MD_ACQ;
         por_q     <= 1'b1;
         rdy_o     <= 1'b1;
         sdo_oe_o  <= 1'b1;
         cfg_clr_o <= 1'b0;
         ana_rst_o <= 1'b0;
      end else begin
         state     <= state_n;
         rdy_o     <= (state_n == MD_ACQ);
         sdo_oe_o  <= (state_n == MD_ACQ) || (state_n == MD_CONV);
         cfg_clr_o <= rst_acc;
         ana_rst_o <= rst_acc & ~app_rst_sel_i;
         if (rst_acc) por_q <= ~app_rst_sel_i;
      end
   end

   assign mode_o = state;

endmodule

// File: rtl/cvt_mode_ctrl_chk.sv
module cvt_mode_ctrl_chk
   import cvt_mode_pkg::*;
#(
   parameter int CONV_CYC = 60
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_i,
   input logic       rdy_i,
   input logic       oe_i,
   input logic       clr_i,
   input logic       ana_i,
   input logic       rst_s_i,
   input logic       start_s_i,
   input logic       sclk_s_i,
   input logic       start_rise_i
);

   localparam int CW = $clog2(CONV_CYC + 2);

   logic [CW-1:0] conv_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_cnt <= '0;
      end else if (mode_i == MD_CONV) begin
         if (rst_s_i) conv_cnt <= conv_cnt + 1'b1;
      end else begin
         conv_cnt <= '0;
      end
   end

   AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !clr_i); // R2
   AST_CLR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |-> (mode_i == MD_RESET) && !rdy_i && !oe_i); // R2
   AST_ANA_WITH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ana_i |-> clr_i); // R3
   AST_EXIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_RECOVER && $past(mode_i) == MD_RESET)
         |-> $past(rst_s_i && !start_s_i && !sclk_s_i)); // R5
   AST_RDY_ACQ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_i |-> (mode_i == MD_ACQ)); // R6
   AST_CONV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_CONV && $past(mode_i) == MD_ACQ) |-> $past(start_rise_i)); // R7
   AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_ACQ && $past(mode_i) == MD_CONV) |-> (conv_cnt == CW'(CONV_CYC))); // R8
   AST_CONV_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_i) == MD_CONV) |-> (mode_i != MD_RECOVER)); // R8
   AST_FROZEN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_s_i && !clr_i && $past(!rst_s_i)) |-> $stable(mode_i)); // R4

endmodule

bind cvt_mode_ctrl cvt_mode_ctrl_chk #(
   .CONV_CYC(CONV_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_i      (mode_o),
   .rdy_i       (rdy_o),
   .oe_i        (sdo_oe_o),
   .clr_i       (cfg_clr_o),
   .ana_i       (ana_rst_o),
   .rst_s_i     (rst_pin_s),
   .start_s_i   (start_s),
   .sclk_s_i    (sclk_s),
   .start_rise_i(start_rise)
);

// File: tb/cvt_mode_ctrl_test.sv
module cvt_mode_ctrl_test;

   localparam int SYN  = 2;
   localparam int MIN  = 4;
   localparam int POR  = 9;
   localparam int APP  = 5;
   localparam int CONV = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rst_pin_n = 1'b1;
   logic       start = 1'b0;
   logic       sclk = 1'b0;
   logic       app_sel = 1'b0;
   logic       rdy_o, sdo_oe_o, cfg_clr_o, ana_rst_o;
   logic [1:0] mode_o;

   int checks = 0;
   int fails  = 0;
   int n_clr  = 0;
   int n_ana  = 0;

   always #5 clk = ~clk;

   cvt_mode_ctrl #(
      .SYNC_STAGES(SYN),
      .MIN_RST_CYC(MIN),
      .POR_DLY_CYC(POR),
      .APP_DLY_CYC(APP),
      .CONV_CYC   (CONV)
   ) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rst_pin_n    (rst_pin_n),
      .start_i      (start),
      .sclk_i       (sclk),
      .app_rst_sel_i(app_sel),
      .rdy_o        (rdy_o),
      .sdo_oe_o     (sdo_oe_o),
      .cfg_clr_o    (cfg_clr_o),
      .ana_rst_o    (ana_rst_o),
      .mode_o       (mode_o)
   );

   always @(posedge clk) begin
      #2;
      if (cfg_clr_o) n_clr++;
      if (ana_rst_o) n_ana++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // clocks until ready has been seen low and then high again
   task automatic wait_ready(output int n);
      bit seen_low;
      seen_low = 1'b0;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (!rdy_o) seen_low = 1'b1;
      end while (!(seen_low && rdy_o) && n < 200);
   endtask

   task automatic run_conv(input int pat, output int lat, output int len);
      start = 1'b1;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         if (pat == 1 && lat == 2) start = 1'b0;
      end while (rdy_o && lat < 40);
      len = 0;
      while (!rdy_o && len < 200) begin
         len++;
         if (pat == 2 && len < CONV - 4) start = ~start;
         else if (pat == 2) start = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int lat, len, n, bad, c0, a0, k, dly;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1: power-up state
      chk(mode_o == 2'b10, "R1 mode", mode_o, 2);
      chk(rdy_o == 1'b1, "R1 rdy", rdy_o, 1);
      chk(sdo_oe_o == 1'b1, "R1 oe", sdo_oe_o, 1);
      chk(n_clr + n_ana == 0, "R1 pulses", n_clr + n_ana, 0);

      // R7 / R8: conversion under three start patterns
      for (int pat = 0; pat < 3; pat++) begin
         run_conv(pat, lat, len);
         chk(lat == SYN + 1, "R7 start-to-busy latency", lat, SYN + 1);
         chk(len == CONV, "R8 conversion length", len, CONV);
         bad = 0;
         repeat (15) begin
            @(negedge clk);
            if (!rdy_o || mode_o != 2'b10) bad++;
         end
         chk(bad == 0, "R8 no restart after conversion", bad, 0);
         start = 1'b0;
         idle(4);
      end

      // R2 / R3 / R4 / R6: pulse width sweep for both flavours
      for (int sel = 0; sel < 2; sel++) begin
         for (int w = 1; w <= MIN + 2; w++) begin
            c0 = n_clr;
            a0 = n_ana;
            app_sel = sel[0];
            rst_pin_n = 1'b0;
            idle(w);
            rst_pin_n = 1'b1;
            if (w < MIN) begin
               bad = 0;
               repeat (6) begin
                  @(negedge clk);
                  if (mode_o != 2'b10 || !rdy_o) bad++;
               end
               chk(bad == 0, "R4 short pulse keeps acquire", bad, 0);
               chk(n_clr == c0, "R4 short pulse no clear", n_clr - c0, 0);
            end else begin
               dly = sel ? APP : POR;
               wait_ready(n);
               chk(n == dly + SYN + 1, "R6 recovery latency", n, dly + SYN + 1);
               chk(n_clr - c0 == 1, "R2 one clear pulse", n_clr - c0, 1);
               chk(n_ana - a0 == (sel ? 0 : 1), "R3 analog pulse by flavour",
                   n_ana - a0, sel ? 0 : 1);
               idle(2);
            end
         end
      end

      // R2: held reset state; R5: start high blocks exit
      app_sel = 1'b0;
      rst_pin_n = 1'b0;
      idle(MIN + 6);
      chk(mode_o == 2'b00, "R2 mode in reset", mode_o, 0);
      chk(!rdy_o && !sdo_oe_o, "R2 rdy/oe low in reset", rdy_o + sdo_oe_o, 0);
      start = 1'b1;
      idle(3);
      rst_pin_n = 1'b1;
      idle(20);
      chk(mode_o == 2'b00, "R5 start high blocks exit", mode_o, 0);
      start = 1'b0;
      wait_ready(n);
      chk(n == POR + SYN + 1, "R6 power-on delay after start drop", n, POR + SYN + 1);
      bad = 0;
      repeat (10) begin
         @(negedge clk);
         if (!rdy_o) bad++;
      end
      chk(bad == 0, "R9 start seen in reset ignored", bad, 0);

      // R5: serial clock high blocks exit
      app_sel = 1'b1;
      sclk = 1'b1;
      rst_pin_n = 1'b0;
      idle(MIN + 4);
      rst_pin_n = 1'b1;
      idle(20);
      chk(mode_o == 2'b00, "R5 sclk high blocks exit", mode_o, 0);
      sclk = 1'b0;
      wait_ready(n);
      chk(n == APP + SYN + 1, "R6 application delay after sclk drop", n, APP + SYN + 1);

      // R9: start pulse during recovery ignored
      rst_pin_n = 1'b0;
      idle(MIN + 3);
      rst_pin_n = 1'b1;
      idle(2);
      chk(mode_o == 2'b00 || mode_o == 2'b01, "R6 in reset or recovery", mode_o, 1);
      start = 1'b1;
      idle(2);
      start = 1'b0;
      wait_ready(n);
      chk(n + 4 == APP + SYN + 1, "R9 recovery length unchanged", n + 4, APP + SYN + 1);
      bad = 0;
      repeat (12) begin
         @(negedge clk);
         if (!rdy_o || mode_o != 2'b10) bad++;
      end
      chk(bad == 0, "R9 no conversion after recovery", bad, 0);

      // R4: short pulse inside a conversion stretches it
      c0 = n_clr;
      start = 1'b1;
      idle(2);
      start = 1'b0;
      n = 0;
      while (rdy_o && n < 20) begin
         @(negedge clk);
         n++;
      end
      len = 1;
      k = 0;
      rst_pin_n = 1'b0;
      while (len < 200) begin
         @(negedge clk);
         k++;
         if (k == 2) rst_pin_n = 1'b1;
         if (!rdy_o) len++;
         else break;
      end
      chk(len == CONV + 2, "R4 frozen conversion length", len, CONV + 2);
      chk(n_clr == c0, "R4 no clear inside conversion", n_clr - c0, 0);
      idle(3);

      // R2: qualified reset taken from conversion
      start = 1'b1;
      idle(2);
      start = 1'b0;
      n = 0;
      while (rdy_o && n < 20) begin
         @(negedge clk);
         n++;
      end
      idle(2);
      c0 = n_clr;
      a0 = n_ana;
      app_sel = 1'b0;
      rst_pin_n = 1'b0;
      idle(MIN + 3);
      chk(mode_o == 2'b00, "R2 reset from conversion", mode_o, 0);
      chk(n_clr - c0 == 1, "R2 clear from conversion", n_clr - c0, 1);
      chk(n_ana - a0 == 1, "R3 analog pulse from conversion", n_ana - a0, 1);
      rst_pin_n = 1'b1;
      wait_ready(n);
      chk(n == POR + SYN + 1, "R6 delay after conversion reset", n, POR + SYN + 1);

      // R10: start edge meeting a falling reset pin is discarded
      c0 = n_clr;
      start = 1'b1;
      rst_pin_n = 1'b0;
      idle(2);
      start = 1'b0;
      rst_pin_n = 1'b1;
      bad = 0;
      repeat (14) begin
         @(negedge clk);
         if (!rdy_o || mode_o != 2'b10) bad++;
      end
      chk(bad == 0, "R10 coincident start discarded", bad, 0);
      chk(n_clr == c0, "R10 no clear pulse", n_clr - c0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule